// File: doc/BRIEF.md
# Status Register Bit-Set Unit

This block keeps a 32-bit machine status word and carries out a single read-then-set operation on it. A one-cycle `go` pulse comes with a 15-bit immediate mask. The unit returns the status value that was visible before the operation on `rd_o`. It then ORs the mask into the status word. Bits that are 1 in the mask become 1, and bits that are 0 in the mask keep their value. The carry bit changes at the operation's clock edge. Every other bit changes one edge later.

Two elaboration-time parameters select the variant. With memory management enabled, the mask is 15 bits wide. In user mode every mask is privileged except one that touches only carry, and a privileged mask in user mode raises a one-cycle exception strobe and loads a cause code. With low-latency interrupt mode enabled, setting the interrupt-enable bit pulses a two-bit acknowledge output. Instruction decode, the register file and exception vectoring belong to neighbouring blocks.

Top module: `srs_unit`

## Requirements
- R1: A synchronous reset drives `status_o`, `rd_o`, `cause_o`, `ack_o` and `exc_o` to zero.
- R2: After the edge that samples `go`, `rd_o` holds the value `status_o` had just before that edge.
- R3: A mask bit of 1 sets the status bit of the same weight. A mask bit of 0 leaves that status bit unchanged.
- R4: The carry bit (bit 2, weight 0x4) is visible on `status_o` right after the operation's edge. All other set bits appear one edge later.
- R5: With USE_MMU=1, mask bits 0 to 14 are used. With USE_MMU=0, only bits 0 to 13 are used and bit 14 is ignored.
- R6: With USE_MMU=1, the user-mode bit (bit 3, weight 0x8) set, and any mask bit other than bit 2 set: no status bit changes, `cause_o` becomes 5'b00111, `exc_o` is 1 for one cycle, and `rd_o` still returns the pre-operation value.
- R7: In user mode, a mask of only 0x4 or a mask of 0 raises no exception.
- R8: With LOW_LAT=1, an operation whose mask has the interrupt-enable bit (bit 1, weight 0x2) set and raises no exception drives `ack_o` to 2'b11 for one cycle. `ack_o` then returns to 2'b00.
- R9: With USE_MMU=0, `exc_o` never asserts, whatever the user-mode bit holds.
- R10: With LOW_LAT=0, `ack_o` stays 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | One-cycle operation start |
| imm | input | 15 | Immediate set mask |
| rd_o | output | 32 | Pre-operation status value |
| status_o | output | 32 | Visible status register |
| ack_o | output | 2 | Interrupt acknowledge |
| exc_o | output | 1 | Privileged-operation exception strobe |
| cause_o | output | 5 | Exception cause code |

## Verification
The set function is driven with several masks:
- A carry-only mask shows the same-edge update apart from the delayed one.
- A lone interrupt-enable mask shows the acknowledge pulse.
- A mid-weight bit and the top mask bit show OR accumulation and the edge of the mask width.
- A zero mask shows that nothing changes.
- A mask that combines carry with an already-set carry shows the two update paths acting together.

User-mode masks that are carry-only, zero, and privileged tell the exempt cases apart from the trapping ones. A second instance with both modes disabled shows that bit 14 is dropped and that user mode has no effect there.

// File: rtl/srs_pkg.sv
package srs_pkg;
    localparam int SR_W      = 32;
    localparam int IMM_W     = 15;
    localparam int CAUSE_W   = 5;
    localparam int ACK_W     = 2;
    localparam int CARRY_BIT = 2;
    localparam int IE_BIT    = 1;
    localparam int UM_BIT    = 3;
    localparam logic [CAUSE_W-1:0] CAUSE_PRIV = 5'b00111;
    localparam logic [ACK_W-1:0]   ACK_ON     = 2'b11;

    typedef struct packed {
        logic [SR_W-1:0]    status;
        logic [SR_W-1:0]    pend;
        logic [SR_W-1:0]    rd;
        logic [CAUSE_W-1:0] cause;
        logic [ACK_W-1:0]   ack;
        logic               exc;
    } srs_state_t;
endpackage

// File: rtl/srs_mask_trim.sv
module srs_mask_trim
    import srs_pkg::*;
#(
    parameter int USE_MMU = 1
) (
    input  logic [IMM_W-1:0] imm,
    output logic [SR_W-1:0]  mask
);
    localparam int EFF_W = (USE_MMU != 0) ? IMM_W : IMM_W - 1;

    generate
        if (EFF_W == IMM_W) begin : g_full
            assign mask = {{(SR_W-IMM_W){1'b0}}, imm};
        end else begin : g_short
            logic unused_top;
            assign unused_top = imm[IMM_W-1];
            assign mask = {{(SR_W-EFF_W){1'b0}}, imm[EFF_W-1:0]};
        end
    endgenerate
endmodule

// File: rtl/srs_priv_chk.sv
module srs_priv_chk
    import srs_pkg::*;
#(
    parameter int USE_MMU = 1
) (
    input  logic            user_mode,
    input  logic [SR_W-1:0] mask,
    output logic            trap
);
    localparam logic [SR_W-1:0] EXEMPT = SR_W'(1) << CARRY_BIT;

    generate
        if (USE_MMU != 0) begin : g_check
            assign trap = user_mode && ((mask & ~EXEMPT) != '0);
        end else begin : g_open
            logic unused_in;
            assign unused_in = user_mode ^ (^mask);
            assign trap = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/srs_unit.sv
module srs_unit
    import srs_pkg::*;
#(
    parameter int USE_MMU = 1,
    parameter int LOW_LAT = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [IMM_W-1:0]   imm,
    output logic [SR_W-1:0]    rd_o,
    output logic [SR_W-1:0]    status_o,
    output logic [ACK_W-1:0]   ack_o,
    output logic               exc_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam logic [SR_W-1:0] CARRY_M = SR_W'(1) << CARRY_BIT;

    srs_state_t st_q, st_d;
    logic [SR_W-1:0] mask;
    logic            trap;

    srs_mask_trim #(.USE_MMU(USE_MMU)) u_trim (
        .imm  (imm),
        .mask (mask)
    );

    srs_priv_chk #(.USE_MMU(USE_MMU)) u_priv (
        .user_mode (st_q.status[UM_BIT]),
        .mask      (mask),
        .trap      (trap)
    );

    always_comb begin
        st_d        = st_q;
        st_d.status = st_q.status | st_q.pend;
        st_d.pend   = '0;
        st_d.ack    = '0;
        st_d.exc    = 1'b0;
        if (go) begin
            st_d.rd = st_q.status;
            if (trap) begin
                st_d.exc   = 1'b1;
                st_d.cause = CAUSE_PRIV;
            end else begin
                st_d.status = st_d.status | (mask & CARRY_M);
                st_d.pend   = mask & ~CARRY_M;
                if ((LOW_LAT != 0) && mask[IE_BIT]) begin
                    st_d.ack = ACK_ON;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_o     = st_q.rd;
    assign status_o = st_q.status;
    assign ack_o    = st_q.ack;
    assign exc_o    = st_q.exc;
    assign cause_o  = st_q.cause;
endmodule

// File: rtl/srs_unit_chk.sv
module srs_unit_chk
    import srs_pkg::*;
#(
    parameter int USE_MMU = 1,
    parameter int LOW_LAT = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               go,
    input logic [SR_W-1:0]    rd_o,
    input logic [SR_W-1:0]    status_o,
    input logic [ACK_W-1:0]   ack_o,
    input logic               exc_o,
    input logic [CAUSE_W-1:0] cause_o
);
    // R2: readout equals the status seen before the operation's edge
    p_rd_pre_r2: assert property (@(posedge clk) disable iff (rst)
        go |=> rd_o == $past(status_o));

    // R3: status bits are only ever set
    p_no_clear_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status_o & $past(status_o)) == $past(status_o));

    // R6: an exception follows an operation and carries the privilege code
    p_exc_cause_r6: assert property (@(posedge clk) disable iff (rst)
        exc_o |-> (cause_o == CAUSE_PRIV) && $past(go));

    // R8: acknowledge is either idle or the full code, only after an operation
    p_ack_code_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_o != 2'b00) |-> (ack_o == ACK_ON) && $past(go) && !exc_o);

    generate
        if (USE_MMU == 0) begin : g_nommu
            // R9
            p_no_exc_r9: assert property (@(posedge clk) disable iff (rst)
                !exc_o);
        end
        if (LOW_LAT == 0) begin : g_nolat
            // R10
            p_no_ack_r10: assert property (@(posedge clk) disable iff (rst)
                ack_o == 2'b00);
        end
    endgenerate
endmodule

bind srs_unit srs_unit_chk #(.USE_MMU(USE_MMU), .LOW_LAT(LOW_LAT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .rd_o     (rd_o),
    .status_o (status_o),
    .ack_o    (ack_o),
    .exc_o    (exc_o),
    .cause_o  (cause_o)
);

// File: tb/sim_srs_unit.sv
module sim_srs_unit;
    typedef struct packed {
        logic [14:0] imm;
        logic [31:0] rd;
        logic [31:0] mid;
        logic [31:0] fin;
        logic [1:0]  ack;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{15'h0004, 32'h0000_0000, 32'h0000_0004, 32'h0000_0004, 2'b00},
        '{15'h0002, 32'h0000_0004, 32'h0000_0004, 32'h0000_0006, 2'b11},
        '{15'h0100, 32'h0000_0006, 32'h0000_0006, 32'h0000_0106, 2'b00},
        '{15'h4001, 32'h0000_0106, 32'h0000_0106, 32'h0000_4107, 2'b00},
        '{15'h0000, 32'h0000_4107, 32'h0000_4107, 32'h0000_4107, 2'b00},
        '{15'h2004, 32'h0000_4107, 32'h0000_4107, 32'h0000_6107, 2'b00}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go0 = 1'b0, go1 = 1'b0;
    logic [14:0] imm0 = '0, imm1 = '0;
    logic [31:0] rd0, st0, rd1, st1;
    logic [1:0]  ack0, ack1;
    logic        exc0, exc1;
    logic [4:0]  cause0, cause1;
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    srs_unit #(.USE_MMU(1), .LOW_LAT(1)) u0 (
        .clk(clk), .rst(rst), .go(go0), .imm(imm0),
        .rd_o(rd0), .status_o(st0), .ack_o(ack0), .exc_o(exc0), .cause_o(cause0)
    );

    srs_unit #(.USE_MMU(0), .LOW_LAT(0)) u1 (
        .clk(clk), .rst(rst), .go(go1), .imm(imm1),
        .rd_o(rd1), .status_o(st1), .ack_o(ack1), .exc_o(exc1), .cause_o(cause1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // mid-cycle samples of u0 after the operation edge
    logic [31:0] m_rd, m_st, f_st;
    logic [1:0]  m_ack, f_ack;
    logic        m_exc, f_exc;

    task automatic op0(input logic [14:0] v);
        @(negedge clk); go0 = 1'b1; imm0 = v;
        @(negedge clk); go0 = 1'b0;
        m_rd = rd0; m_st = st0; m_ack = ack0; m_exc = exc0;
        @(negedge clk);
        f_st = st0; f_ack = ack0; f_exc = exc0;
    endtask

    task automatic op1(input logic [14:0] v);
        @(negedge clk); go1 = 1'b1; imm1 = v;
        @(negedge clk); go1 = 1'b0;
        m_rd = rd1; m_st = st1; m_ack = ack1; m_exc = exc1;
        @(negedge clk);
        f_st = st1; f_ack = ack1; f_exc = exc1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 status", st0, 32'h0);
        chk("R1 rd", rd0, 32'h0);
        chk("R1 cause", {27'h0, cause0}, 32'h0);
        chk("R1 ack/exc", {29'h0, ack0, exc0}, 32'h0);
        rst = 1'b0;

        // R2 R3 R4 R5 R8: table walk on u0
        for (int i = 0; i < NV; i++) begin
            op0(VEC[i].imm);
            chk("R2 rd pre-op", m_rd, VEC[i].rd);
            chk("R4 carry same edge", m_st, VEC[i].mid);
            chk("R3 set bits", f_st, VEC[i].fin);
            chk("R8 ack pulse", {30'h0, m_ack}, {30'h0, VEC[i].ack});
            chk("R8 ack released", {30'h0, f_ack}, 32'h0);
        end

        // R9 R5 R10: u1 without memory management or low latency
        op1(15'h0008);
        chk("R9 u1 user set", f_st, 32'h8);
        op1(15'h0010);
        chk("R9 no exc in user mode", {31'h0, m_exc}, 32'h0);
        chk("R9 bits set", f_st, 32'h18);
        op1(15'h7FFF);
        chk("R2 u1 rd", m_rd, 32'h18);
        chk("R4 u1 carry first", m_st, 32'h1C);
        chk("R5 bit14 ignored", f_st, 32'h3FFF);
        chk("R10 no ack", {30'h0, m_ack}, 32'h0);

        // R6 R7: user mode on u0
        op0(15'h0008);
        chk("R3 enter user", f_st, 32'h610F);
        op0(15'h0010);
        chk("R6 exc strobe", {31'h0, m_exc}, 32'h1);
        chk("R6 exc one cycle", {31'h0, f_exc}, 32'h0);
        chk("R6 cause", {27'h0, cause0}, 32'h7);
        chk("R6 rd pre-op", m_rd, 32'h610F);
        chk("R6 status held mid", m_st, 32'h610F);
        chk("R6 status held", f_st, 32'h610F);
        op0(15'h0004);
        chk("R7 carry-only no exc", {31'h0, m_exc}, 32'h0);
        op0(15'h0000);
        chk("R7 zero no exc", {31'h0, m_exc}, 32'h0);
        chk("R7 zero status", f_st, 32'h610F);
        op0(15'h0002);
        chk("R6 ie trap", {31'h0, m_exc}, 32'h1);
        chk("R8 no ack on trap", {30'h0, m_ack}, 32'h0);

        // R1: reset after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R1 status cleared", st0, 32'h0);
        chk("R1 rd cleared", rd0, 32'h0);
        chk("R1 cause cleared", {27'h0, cause0}, 32'h0);
        chk("R1 u1 cleared", st1, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule